// File: doc/BRIEF.md
# Converter Acquisition Sequencer

This block decides when an oversampling converter is powered, when it is given time to settle, and which of its output samples are passed on. A power-on request starts a fixed settling interval. Conversion follows. While converting, the block divides the modulator clock by the oversampling ratio to make one sample strobe per output period. It drops a programmable number of leading samples, forwards the samples after them, and ends the run on a programmable sample count with a one-clock completion pulse. A sticky completion flag also records the end of the run.

When a run ends, a mode bit selects what happens next. In auto-stop mode the converter is powered down. In stay-on mode it stays powered, and a separate start trigger begins each new run with no settling interval. After every stop there is a holdoff of two sample periods. A request that arrives during the holdoff is remembered and acted on when the holdoff ends. A lock output shows that a run, including its settling interval, is in progress. The analog converter is not part of this block: the strobe stands in for its sample-valid signal.

Top module: `acq_sequencer`

## Requirements
- R1: While converting, `smp_strobe` is high for one clock every `osr` clocks (an `osr` of 0 acts as 1). The first strobe comes `osr` clocks after conversion begins.
- R2: `arm_req` while powered down with no holdoff raises `conv_pwr` and `lock` on the next clock. It then keeps `conv_run` low for SETTLE_CLKS clocks (default 32) before conversion begins.
- R3: Strobes are numbered 1, 2, … within a run. Strobes 1 to `skip_cnt` have `smp_valid` low. Later strobes have `smp_valid` high.
- R4: `acq_done` is high for exactly one clock, on strobe number `total_cnt`+1. Conversion ends on the next clock.
- R5: With `stay_on` = 0 at completion, `conv_pwr` falls on the clock after `acq_done`.
- R6: With `stay_on` = 1 at completion, `conv_pwr` stays high. A `start_trig` then begins conversion on the next clock with no settling, and its first strobe follows `osr` clocks later.
- R7: `arm_req` while powered and idle has no effect. `start_trig` while powered down has no effect.
- R8: For 2×`osr` clocks after the clock following `acq_done`, no new run begins. A request made in that window is held and starts the run on the clock the window ends.
- R9: `lock` is high during settling and conversion and low otherwise.
- R10: `done_flag` goes high on the clock after `acq_done` and stays high until `done_clr` is pulsed.
- R11: Dropping `stay_on` while powered and idle lowers `conv_pwr` on the next clock.
- R12: After reset `conv_pwr`, `conv_run`, `lock`, `acq_done` and `done_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_req | input | 1 | Power-on request, one-clock pulse |
| start_trig | input | 1 | Start of a new run while powered in stay-on mode, pulse |
| stay_on | input | 1 | 1: stay powered after a run; 0: power down |
| skip_cnt | input | CW | Number of leading samples discarded |
| total_cnt | input | CW | Run ends on strobe total_cnt+1 |
| osr | input | OW | Oversampling ratio, modulator clocks per sample |
| done_clr | input | 1 | Clears the completion flag when high |
| conv_pwr | output | 1 | Converter power enable |
| conv_run | output | 1 | Converter is converting |
| smp_strobe | output | 1 | Output sample period strobe |
| smp_valid | output | 1 | Strobe whose sample is forwarded |
| acq_done | output | 1 | One-clock completion pulse |
| done_flag | output | 1 | Sticky completion flag |
| lock | output | 1 | Run in progress, read-only status |

## Verification
The bench numbers every rising edge and computes when each result is due from the edge that captured the request. After an `arm_req` captured on edge a+1, `conv_run` appears at cycle a+1+SETTLE_CLKS. Strobe k then appears at a+SETTLE_CLKS+k·`osr`, with `acq_done` on strobe `total_cnt`+1 and the power result one cycle after that. A `start_trig` captured on edge b+1 gives its first strobe at b+`osr`. A request held through the holdoff shows `conv_pwr` still low at D+1+2·`osr` and high one cycle later, where D is the cycle of `acq_done`. All of these are compared on falling edges, every cycle in the window, so a strobe that is one clock early or late is caught.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_READY  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_clkdiv.sv
module acq_clkdiv #(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [OW-1:0] osr,
  output logic          strobe
);
  logic [OW-1:0] phase_q;

  // last phase of one output period; ratio 0 is treated as 1
  function automatic logic [OW-1:0] last_phase(input logic [OW-1:0] r);
    return (r == '0) ? '0 : r - 1'b1;
  endfunction

  assign strobe = run && (phase_q == last_phase(osr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= strobe ? '0 : phase_q + 1'b1;
  end

  // R1: a restart always leaves the divider at phase zero
  p_restart_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == '0));
endmodule

// File: rtl/acq_smpcount.sv
module acq_smpcount #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          strobe,
  input  logic [CW-1:0] skip_cnt,
  input  logic [CW-1:0] total_cnt,
  output logic          fwd_valid,
  output logic          last_smp
);
  logic [CW-1:0] seen_q;   // strobes already passed in this run

  function automatic logic is_kept(input logic [CW-1:0] seen, input logic [CW-1:0] skip);
    return seen >= skip;
  endfunction

  function automatic logic is_last(input logic [CW-1:0] seen, input logic [CW-1:0] total);
    return seen == total;
  endfunction

  assign fwd_valid = strobe && is_kept(seen_q, skip_cnt);
  assign last_smp  = strobe && is_last(seen_q, total_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen_q <= '0;
    else if (restart)             seen_q <= '0;
    else if (strobe && !last_smp) seen_q <= seen_q + 1'b1;
  end

  // R3: the count moves only on a strobe
  p_count_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !restart) |=> $stable(seen_q));
endmodule

// File: rtl/acq_holdoff.sv
module acq_holdoff #(
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cancel,
  input  logic          req,
  input  logic [OW-1:0] osr,
  output logic          busy,
  output logic          fire
);
  logic [OW:0] left_q;
  logic        pend_q;

  // two output sample periods in modulator clocks
  function automatic logic [OW:0] holdoff_len(input logic [OW-1:0] r);
    logic [OW:0] eff;
    eff = (r == '0) ? (OW+1)'(1) : {1'b0, r};
    return eff << 1;
  endfunction

  assign busy = (left_q != '0);
  assign fire = (req || pend_q) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= holdoff_len(osr);
    else if (busy)  left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (cancel || fire)   pend_q <= 1'b0;
    else if (req)              pend_q <= 1'b1;
  end

  // R8: a request seen while busy is kept
  p_pend_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && busy && !cancel) |=> pend_q);
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int CW          = 8,
  parameter int OW          = 8,
  parameter int SETTLE_CLKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_req,
  input  logic          start_trig,
  input  logic          stay_on,
  input  logic [CW-1:0] skip_cnt,
  input  logic [CW-1:0] total_cnt,
  input  logic [OW-1:0] osr,
  input  logic          done_clr,
  output logic          conv_pwr,
  output logic          conv_run,
  output logic          smp_strobe,
  output logic          smp_valid,
  output logic          acq_done,
  output logic          done_flag,
  output logic          lock
);
  localparam int              SW          = $clog2(SETTLE_CLKS + 2);
  localparam logic [SW-1:0]   SETTLE_LOAD = SW'(SETTLE_CLKS);

  acq_state_e    st_q;
  logic [SW-1:0] settle_q;
  logic          go_req, go_fire, hold_busy, cancel_pend, restart, settle_end;

  function automatic logic settle_over(input logic [SW-1:0] left);
    return left <= SW'(1);
  endfunction

  assign go_req      = ((st_q == ST_OFF) && arm_req) || ((st_q == ST_READY) && start_trig);
  assign cancel_pend = (st_q == ST_READY) && !stay_on;
  assign settle_end  = (st_q == ST_SETTLE) && settle_over(settle_q);
  assign restart     = settle_end || ((st_q == ST_READY) && stay_on && go_fire);

  acq_holdoff #(.OW(OW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(acq_done), .cancel(cancel_pend),
    .req(go_req), .osr(osr), .busy(hold_busy), .fire(go_fire));

  acq_clkdiv #(.OW(OW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(conv_run), .restart(restart),
    .osr(osr), .strobe(smp_strobe));

  acq_smpcount #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .strobe(smp_strobe),
    .skip_cnt(skip_cnt), .total_cnt(total_cnt),
    .fwd_valid(smp_valid), .last_smp(acq_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      settle_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: if (go_fire) begin
          st_q     <= ST_SETTLE;
          settle_q <= SETTLE_LOAD;
        end
        ST_SETTLE: begin
          if (settle_end) st_q <= ST_CONV;
          else            settle_q <= settle_q - 1'b1;
        end
        ST_CONV: if (acq_done) st_q <= stay_on ? ST_READY : ST_OFF;
        ST_READY: begin
          if (!stay_on)     st_q <= ST_OFF;
          else if (go_fire) st_q <= ST_CONV;
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_flag <= 1'b0;
    else if (acq_done) done_flag <= 1'b1;
    else if (done_clr) done_flag <= 1'b0;
  end

  assign conv_pwr = (st_q != ST_OFF);
  assign conv_run = (st_q == ST_CONV);
  assign lock     = (st_q == ST_SETTLE) || (st_q == ST_CONV);

  // R2: settling never produces a sample strobe
  p_settle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE) |-> !smp_strobe);
  // R4: the completion pulse lasts one clock
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done);
  // R5: auto-stop powers down after completion
  p_autostop_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && !stay_on) |=> !conv_pwr);
  // R6: stay-on keeps power after completion
  p_stayon_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && stay_on) |=> (conv_pwr && !lock));
  // R8: completion starts the holdoff window
  p_done_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> hold_busy);
  // R8: a new run starts only when the holdoff was over
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(!hold_busy));
  // R9: lock implies power
  p_lock_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> conv_pwr);
  // R10: completion sets the sticky flag
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> done_flag);
endmodule

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
  localparam int S = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_req = 1'b0, start_trig = 1'b0, stay_on = 1'b0, done_clr = 1'b0;
  logic [7:0] skip_cnt = '0, total_cnt = '0, osr = 8'd4;
  logic conv_pwr, conv_run, smp_strobe, smp_valid, acq_done, done_flag, lock;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acq_sequencer #(.CW(8), .OW(8), .SETTLE_CLKS(S)) uut (
    .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .start_trig(start_trig),
    .stay_on(stay_on), .skip_cnt(skip_cnt), .total_cnt(total_cnt), .osr(osr),
    .done_clr(done_clr), .conv_pwr(conv_pwr), .conv_run(conv_run),
    .smp_strobe(smp_strobe), .smp_valid(smp_valid), .acq_done(acq_done),
    .done_flag(done_flag), .lock(lock));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arm_req = 1'b0; start_trig = 1'b0; done_clr = 1'b0;
    end
  endtask

  // follows one run until one cycle after completion; f = cycle of first strobe
  task automatic watch(input int f, input int m, input int n, input int r, input bit stay);
    int bad_s = 0, bad_v = 0, bad_d = 0, bad_l = 0, bad_r = 0;
    int last = f + n * r;
    int c;
    do begin
      @(negedge clk);
      c = cyc;
      begin
        bit es, ev, ed;
        int k;
        es = (c >= f) && (((c - f) % r) == 0);
        k  = (c >= f) ? ((c - f) / r + 1) : 0;
        ev = es && (k > m);
        ed = es && (k == n + 1);
        if (smp_strobe !== es) bad_s++;
        if (smp_valid !== ev) bad_v++;
        if (acq_done !== ed) bad_d++;
        if (lock !== 1'b1 || conv_pwr !== 1'b1) bad_l++;
        if (conv_run !== (c >= f - r + 1)) bad_r++;
      end
      arm_req = 1'b0; start_trig = 1'b0;
    end while (c < last);
    chk(bad_s == 0, "R1 strobe spacing", bad_s, 0);
    chk(bad_r == 0, "R2 settle before conversion", bad_r, 0);
    chk(bad_v == 0, "R3 discard of leading samples", bad_v, 0);
    chk(bad_d == 0, "R4 completion on last strobe", bad_d, 0);
    chk(bad_l == 0, "R9 lock during run", bad_l, 0);
    @(negedge clk);
    chk(conv_pwr == stay, stay ? "R6 power kept" : "R5 power dropped", conv_pwr, stay);
    chk(lock == 1'b0, "R9 lock released", lock, 0);
    chk(conv_run == 1'b0, "R4 conversion ended", conv_run, 0);
  endtask

  task automatic t_reset;
    chk(conv_pwr == 0 && conv_run == 0, "R12 reset power", conv_pwr, 0);
    chk(lock == 0, "R12 reset lock", lock, 0);
    chk(acq_done == 0, "R12 reset done pulse", acq_done, 0);
    chk(done_flag == 0, "R12 reset flag", done_flag, 0);
  endtask

  task automatic t_auto(input int m, input int n, input int r);
    int a;
    stay_on = 1'b0; skip_cnt = 8'(m); total_cnt = 8'(n); osr = 8'(r);
    arm_req = 1'b1;
    a = cyc;
    watch(a + S + r, m, n, r, 1'b0);
  endtask

  // arm during the holdoff that follows a run, must be held
  task automatic t_held_arm(input int r);
    int d1;
    d1 = cyc;                 // = done cycle + 1
    arm_req = 1'b1;
    skip_cnt = 8'd0; total_cnt = 8'd1;
    while (cyc < d1 + 2 * r) idle(1);
    chk(conv_pwr == 0, "R8 holdoff blocks arm", conv_pwr, 0);
    idle(1);
    chk(conv_pwr == 1 && lock == 1, "R8 held arm acted on", conv_pwr, 1);
    watch(d1 + 2 * r + S + r, 0, 1, r, 1'b0);
  endtask

  task automatic t_flag;
    chk(done_flag == 1, "R10 flag sticky", done_flag, 1);
    idle(3);
    chk(done_flag == 1, "R10 flag holds", done_flag, 1);
    done_clr = 1'b1;
    idle(1);
    chk(done_flag == 0, "R10 flag cleared", done_flag, 0);
  endtask

  task automatic t_stayon;
    int b;
    idle(20);
    stay_on = 1'b1; skip_cnt = 8'd1; total_cnt = 8'd3; osr = 8'd3;
    arm_req = 1'b1;
    b = cyc;
    watch(b + S + 3, 1, 3, 3, 1'b1);
    idle(20);
    skip_cnt = 8'd2; total_cnt = 8'd4;
    start_trig = 1'b1;
    b = cyc;
    watch(b + 3, 2, 4, 3, 1'b1);   // no settling: R6
  endtask

  task automatic t_ignored;
    int bad = 0;
    idle(20);
    arm_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      idle(1);
      if (lock !== 1'b0 || smp_strobe !== 1'b0) bad++;
    end
    chk(bad == 0 && conv_pwr == 1, "R7 arm ignored while ready", bad, 0);
    stay_on = 1'b0;
    idle(1);
    chk(conv_pwr == 0, "R11 drop of stay_on powers down", conv_pwr, 0);
    bad = 0;
    start_trig = 1'b1;
    for (int i = 0; i < 10; i++) begin
      idle(1);
      if (conv_pwr !== 1'b0) bad++;
    end
    chk(bad == 0, "R7 start ignored while off", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_auto(2, 5, 4);
    t_held_arm(4);
    t_flag();
    t_stayon();
    t_ignored();
    idle(20);
    t_auto(0, 0, 1);
    idle(20);
    t_auto(3, 3, 2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc == 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule